// File: doc/BRIEF.md
# Run-Time Selectable Pseudo-Noise Sequence Generator

This block produces a maximal-length pseudo-noise sequence from a Fibonacci linear-feedback shift register whose active length can be chosen on the fly, anywhere from 3 to 32 stages. A built-in table supplies a feedback tap set for every length, so a design can switch between short and long sequences without reconfiguring. The feedback can be a plain XOR or its complement (XNOR). The block detects and escapes the single illegal lockup state of either polarity. A one-cycle flag marks every return of the register to the value it started from.

A small controller picks one action per clock cycle and records it in its phase register. The actions are PH_LOAD (seed or default reload), PH_RUN (one shift), PH_ESCAPE (recovery from the lockup state) and PH_PAUSE (hold). Reset, a seed strobe or a new length always lead to PH_LOAD. Otherwise a low enable leads to PH_PAUSE. Otherwise an illegal current state leads to PH_ESCAPE, and any remaining cycle leads to PH_RUN. Any phase may move to any other on the next cycle under these rules.

Top module: `pn_seq_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, the state becomes the default seed for the current mode (all ones over the selected length in XOR mode, zero in XNOR mode), the length is captured, and `period_pulse` is 0.
- R2: On each enabled step the state becomes {state[N-2:0], fb}. fb is the XOR of the tapped bits. Bit N-1 is always a tap. Examples: N=4 uses taps 3,2 and N=8 uses taps 7,5,4,3. Every length from 3 to 32 has its own entry.
- R3: For every length N, the stepped sequence visits 2^N-1 distinct states before it repeats, in both modes.
- R4: With `xnor_mode`=1, fb is the inverse of the XOR of the taps, and the all-ones state over N bits is the illegal state.
- R5: If the state is illegal on an enabled step, the next state is the recovery value: all ones in XOR mode (from all zeros), zero in XNOR mode (from all ones).
- R6: `seed_ld` loads `seed` regardless of `en` and takes priority over shifting. A seed that is illegal for the current mode is replaced by the recovery value on the same load.
- R7: State bits at position N and above always read 0, and seed bits above the selected length have no effect.
- R8: A change of `len_sel` reloads the default seed for the new length on the next edge, unless a seed is loaded on that edge.
- R9: `pn_out` equals state bit N-1.
- R10: `period_pulse` is high for one cycle after each step whose result equals the value captured at the last load or reset.
- R11: With `en` low and no load pending, the state holds and `period_pulse` stays 0.
- R12: A `len_sel` value below 3 selects 3 stages, and a value above 32 selects 32 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| len_sel | input | 6 | Requested register length (clamped to 3..32) |
| seed_ld | input | 1 | Seed load strobe |
| seed | input | 32 | Seed value, masked to the selected length |
| xnor_mode | input | 1 | 0: XOR feedback, 1: XNOR feedback |
| state_q | output | 32 | Current register state, zero above the length |
| pn_out | output | 1 | Serial pseudo-noise bit (state bit N-1) |
| period_pulse | output | 1 | One-cycle flag on return to the captured start value |

## Verification
The assertions assume that `rst` is applied on the first clock edges, and that `xnor_mode` is steady around any edge on which the escape or seed-load properties judge the result. The stimulus changes `xnor_mode` only while `en` is low or one full cycle before a step. The sweeps load a legal seed before each period count, so the start value lies on the maximal cycle. Deliberate lockup entries are made only by flipping the mode, which puts a legal state into the other polarity's illegal value.

// File: rtl/pn_pkg.sv
package pn_pkg;

    localparam int MAX_LEN = 32;
    localparam int MIN_LEN = 3;
    localparam int LW      = $clog2(MAX_LEN + 1);

    typedef logic [MAX_LEN-1:0] word_t;
    typedef logic [LW-1:0]      len_t;

    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_RUN    = 2'd1,
        PH_ESCAPE = 2'd2,
        PH_PAUSE  = 2'd3
    } phase_e;

    function automatic len_t clamp_len(input len_t raw);
        if (raw < len_t'(MIN_LEN))
            return len_t'(MIN_LEN);
        else if (raw > len_t'(MAX_LEN))
            return len_t'(MAX_LEN);
        else
            return raw;
    endfunction

    // Feedback taps per length, bit i set when stage i feeds the XOR.
    function automatic word_t tap_set(input len_t n);
        case (n)
            6'd3:  return 32'h0000_0006;
            6'd4:  return 32'h0000_000C;
            6'd5:  return 32'h0000_0014;
            6'd6:  return 32'h0000_0030;
            6'd7:  return 32'h0000_0060;
            6'd8:  return 32'h0000_00B8;
            6'd9:  return 32'h0000_0110;
            6'd10: return 32'h0000_0240;
            6'd11: return 32'h0000_0500;
            6'd12: return 32'h0000_0829;
            6'd13: return 32'h0000_100D;
            6'd14: return 32'h0000_2015;
            6'd15: return 32'h0000_6000;
            6'd16: return 32'h0000_D008;
            6'd17: return 32'h0001_2000;
            6'd18: return 32'h0002_0400;
            6'd19: return 32'h0004_0023;
            6'd20: return 32'h0009_0000;
            6'd21: return 32'h0014_0000;
            6'd22: return 32'h0030_0000;
            6'd23: return 32'h0042_0000;
            6'd24: return 32'h00E1_0000;
            6'd25: return 32'h0120_0000;
            6'd26: return 32'h0200_0023;
            6'd27: return 32'h0400_0013;
            6'd28: return 32'h0900_0000;
            6'd29: return 32'h1400_0000;
            6'd30: return 32'h2000_0029;
            6'd31: return 32'h4800_0000;
            6'd32: return 32'h8020_0003;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pn_tap_rom.sv
module pn_tap_rom
    import pn_pkg::*;
(
    input  len_t  len,
    output word_t taps,
    output word_t mask
);
    assign taps = tap_set(len);

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_mask
        assign mask[g] = (len_t'(g) < len);
    end

endmodule

// File: rtl/pn_ctrl.sv
module pn_ctrl
    import pn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   seed_ld,
    input  len_t   len_sel,
    input  logic   illegal,
    output len_t   len_q,
    output len_t   len_nxt,
    output phase_e act,
    output logic   load_seed,
    output logic   step
);
    phase_e ph_q;
    logic   len_change;

    assign len_nxt    = clamp_len(len_sel);
    assign len_change = (len_nxt != len_q);

    // Next-action decision (the phase taken on the coming edge).
    always_comb begin
        if (seed_ld || len_change)
            act = PH_LOAD;
        else if (!en)
            act = PH_PAUSE;
        else if (illegal)
            act = PH_ESCAPE;
        else
            act = PH_RUN;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_LOAD;
            len_q <= len_nxt;
        end else begin
            ph_q  <= act;
            len_q <= len_nxt;
        end
    end

    // Output decode.
    always_comb begin
        load_seed = 1'b0;
        step      = 1'b0;
        unique case (act)
            PH_LOAD:   load_seed = seed_ld;
            PH_RUN:    step      = 1'b1;
            PH_ESCAPE: step      = 1'b1;
            PH_PAUSE:  step      = 1'b0;
        endcase
    end

    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (len_q >= len_t'(MIN_LEN)) && (len_q <= len_t'(MAX_LEN))); // R12

    AST_PAUSE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_PAUSE) |-> !$past(en)); // R11

endmodule

// File: rtl/pn_shift.sv
module pn_shift
    import pn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   xnor_mode,
    input  phase_e act,
    input  logic   load_seed,
    input  word_t  seed,
    input  word_t  taps_n,
    input  word_t  mask_n,
    input  word_t  mask_q,
    output word_t  state_q,
    output word_t  state_d,
    output logic   illegal
);
    word_t ill_n, rec_n, cand, shifted;
    logic  fb;

    assign illegal = xnor_mode ? (state_q == mask_q) : (state_q == '0);
    assign ill_n   = xnor_mode ? mask_n : '0;
    assign rec_n   = xnor_mode ? '0 : mask_n;
    assign fb      = (^(state_q & taps_n)) ^ xnor_mode;
    assign shifted = ({state_q[MAX_LEN-2:0], 1'b0} | word_t'(fb)) & mask_n;
    assign cand    = load_seed ? (seed & mask_n) : rec_n;

    always_comb begin
        if (rst) begin
            state_d = rec_n;
        end else begin
            unique case (act)
                PH_LOAD:   state_d = (cand == ill_n) ? rec_n : cand;
                PH_RUN:    state_d = shifted;
                PH_ESCAPE: state_d = rec_n;
                PH_PAUSE:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (act == PH_PAUSE) |=> $stable(state_q)); // R11

    AST_ABOVE_LEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q & ~mask_q) == '0); // R7

    AST_XOR_ESCAPE: assert property (@(posedge clk) disable iff (rst)
        (act == PH_ESCAPE && !xnor_mode) |=> (state_q == mask_q)); // R5

    AST_XNOR_ESCAPE: assert property (@(posedge clk) disable iff (rst)
        (act == PH_ESCAPE && xnor_mode) |=> (state_q == '0)); // R5

    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (load_seed && ((seed & mask_n) != ill_n)) |=> (state_q == $past(seed & mask_n))); // R6

endmodule

// File: rtl/pn_period.sv
module pn_period
    import pn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    input  word_t state_d,
    output logic  pulse
);
    word_t start_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            start_q <= state_d;
        pulse <= !rst && step && (state_d == start_q);
    end

    AST_PULSE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(step)); // R10

endmodule

// File: rtl/pn_seq_gen.sv
module pn_seq_gen
    import pn_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [5:0]  len_sel,
    input  logic        seed_ld,
    input  logic [31:0] seed,
    input  logic        xnor_mode,
    output logic [31:0] state_q,
    output logic        pn_out,
    output logic        period_pulse
);
    len_t   len_q, len_nxt;
    phase_e act;
    logic   load_seed, step, illegal;
    word_t  taps_n, mask_n, taps_q, mask_q, state_d;

    pn_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .seed_ld   (seed_ld),
        .len_sel   (len_t'(len_sel)),
        .illegal   (illegal),
        .len_q     (len_q),
        .len_nxt   (len_nxt),
        .act       (act),
        .load_seed (load_seed),
        .step      (step)
    );

    pn_tap_rom u_rom_nxt (
        .len  (len_nxt),
        .taps (taps_n),
        .mask (mask_n)
    );

    pn_tap_rom u_rom_cur (
        .len  (len_q),
        .taps (taps_q),
        .mask (mask_q)
    );

    pn_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .xnor_mode (xnor_mode),
        .act       (act),
        .load_seed (load_seed),
        .seed      (seed),
        .taps_n    (taps_n),
        .mask_n    (mask_n),
        .mask_q    (mask_q),
        .state_q   (state_q),
        .state_d   (state_d),
        .illegal   (illegal)
    );

    pn_period u_period (
        .clk     (clk),
        .rst     (rst),
        .load    (act == PH_LOAD),
        .step    (step),
        .state_d (state_d),
        .pulse   (period_pulse)
    );

    assign pn_out = |(state_q & ~(mask_q >> 1) & mask_q);

    AST_TOP_TAP_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (taps_q & (mask_q ^ (mask_q >> 1))) != '0); // R2

    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        period_pulse |-> $past(en)); // R11

    AST_LEN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!seed_ld && (len_nxt != len_q) && !xnor_mode) |=> (state_q == $past(mask_n))); // R8

endmodule

// File: tb/pn_seq_gen_bench.sv
module pn_seq_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [5:0]  len_sel = 6'd8;
    logic        seed_ld = 1'b0;
    logic [31:0] seed = '0;
    logic        xnor_mode = 1'b0;
    logic [31:0] state_q;
    logic        pn_out;
    logic        period_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit seen [0:4095];

    always #2 clk = ~clk;

    pn_seq_gen u_pn_seq_gen (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .len_sel      (len_sel),
        .seed_ld      (seed_ld),
        .seed         (seed),
        .xnor_mode    (xnor_mode),
        .state_q      (state_q),
        .pn_out       (pn_out),
        .period_pulse (period_pulse)
    );

    // N=4, XOR taps 3,2, states after each step starting from 4'h1.
    localparam logic [3:0] SEQ4 [0:14] = '{
        4'h2, 4'h4, 4'h9, 4'h3, 4'h6, 4'hD, 4'hA, 4'h5,
        4'hB, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8, 4'h1
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] v);
        seed_ld = 1'b1;
        seed    = v;
        tick();
        seed_ld = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset in XOR mode with length 8
        tick();
        tick();
        check(state_q == 32'hFF, "R1", state_q, 32'hFF);
        check(period_pulse == 1'b0, "R1", period_pulse, 0);
        check(pn_out == 1'b1, "R9", pn_out, 1);
        xnor_mode = 1'b1;
        tick();
        check(state_q == 32'h0, "R1", state_q, 0);
        rst = 1'b0;
        xnor_mode = 1'b0;

        // R8: length change reloads default
        len_sel = 6'd4;
        tick();
        check(state_q == 32'hF, "R8", state_q, 32'hF);

        // R7: upper seed bits ignored
        load(32'hFFFF_FFF1);
        check(state_q == 32'h1, "R7", state_q, 1);

        // R2, R9, R10: vector walk of the 4-stage sequence
        en = 1'b1;
        for (int k = 0; k < 15; k++) begin
            tick();
            check(state_q == 32'(SEQ4[k]), "R2", state_q, 32'(SEQ4[k]));
            check(pn_out == SEQ4[k][3], "R9", pn_out, SEQ4[k][3]);
            check(period_pulse == (k == 14), "R10", period_pulse, (k == 14));
        end

        // R11: hold with enable low
        en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            check(state_q == 32'h1 && !period_pulse, "R11", {state_q[30:0], period_pulse}, 32'h2);
        end

        // R4: XNOR stepping from zero
        xnor_mode = 1'b1;
        load(32'h0);
        en = 1'b1;
        tick(); check(state_q == 32'h1, "R4", state_q, 32'h1);
        tick(); check(state_q == 32'h3, "R4", state_q, 32'h3);
        tick(); check(state_q == 32'h7, "R4", state_q, 32'h7);
        tick(); check(state_q == 32'hE, "R4", state_q, 32'hE);
        en = 1'b0;

        // R6: illegal seed replaced in both modes
        load(32'hF);
        check(state_q == 32'h0, "R6", state_q, 0);
        xnor_mode = 1'b0;
        tick();
        // R5: state 0 is illegal in XOR mode, escape to all ones
        en = 1'b1;
        tick();
        check(state_q == 32'hF, "R5", state_q, 32'hF);
        en = 1'b0;
        xnor_mode = 1'b1;
        tick();
        en = 1'b1;
        tick();
        check(state_q == 32'h0, "R5", state_q, 0);
        en = 1'b0;
        xnor_mode = 1'b0;
        load(32'h0);
        check(state_q == 32'hF, "R6", state_q, 32'hF);

        // R12: clamping of the length select
        len_sel = 6'd1;
        tick();
        check(state_q == 32'h7, "R12", state_q, 32'h7);
        check(pn_out == 1'b1, "R9", pn_out, 1);
        len_sel = 6'd50;
        tick();
        check(state_q == 32'hFFFF_FFFF, "R12", state_q, 32'hFFFF_FFFF);
        len_sel = 6'd0;
        tick();
        check(state_q == 32'h7, "R12", state_q, 32'h7);

        // R3: full period and distinctness for short lengths, both modes
        for (int m = 0; m < 2; m++) begin
            for (int n = 3; n <= 12; n++) begin
                int cnt;
                bit dup;
                en = 1'b0;
                xnor_mode = m[0];
                len_sel = 6'(n);
                tick();
                load(32'h5);
                for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
                seen[state_q[11:0]] = 1'b1;
                cnt = 0;
                dup = 1'b0;
                en = 1'b1;
                while (cnt < (1 << n) + 2) begin
                    tick();
                    cnt++;
                    if (period_pulse) break;
                    if (seen[state_q[11:0]]) dup = 1'b1;
                    seen[state_q[11:0]] = 1'b1;
                end
                check(cnt == (1 << n) - 1, "R3", cnt, (1 << n) - 1);
                check(!dup, "R3", dup, 0);
            end
        end

        // R3: period of the 16-stage sequence
        begin
            int cnt;
            en = 1'b0;
            xnor_mode = 1'b0;
            len_sel = 6'd16;
            tick();
            load(32'h1234);
            cnt = 0;
            en = 1'b1;
            while (cnt < 70000) begin
                tick();
                cnt++;
                if (period_pulse) break;
            end
            check(cnt == 65535, "R3", cnt, 65535);
            en = 1'b0;
        end

        summary();
    end

endmodule